// File: doc/BRIEF.md
# Clock Synthesizer Configuration Register Bank

This block holds the configuration bytes of a programmable PLL clock generator and turns them into the decoded values that the synthesizer needs. Software-side logic, for example a two-wire serial slave, writes bytes over an 8-bit address, 8-bit data write channel. Any address can be read back combinationally through a separate read port. Eleven addresses are live. Every other address is reserved: a write there is dropped and latches an error flag, and a read there returns zero.

Some bits of the live registers have fixed values. The bank forces those bits on every write, so they always read back with the values the synthesizer requires. From the stored fields the block computes the reference divisor, the feedback multiplier, the post-divider settings and the crosspoint source for each of the six outputs. It also flags settings that would make the PLL unstable: a multiplier outside the supported range, a reserved charge-pump code, a pump code that does not suit the current multiplier, and a post-divider value below the supported minimum.

The write channel uses valid/ready. A write is accepted on a rising clock edge where both `wr_valid` and `wr_ready` are high. While `wr_valid` is high, the sender must hold `wr_addr` and `wr_data` steady until the write is accepted. `wr_ready` is low during reset and in the first cycle after reset is released, and high at all other times. Read and status pins are plain signals with no handshake.

Top module: `clkcfg_bank`

## Requirements
- R1: Reset is synchronous and active low. After a clock edge with `rst_n` low, all output enables are off, PB, PO and Q are zero (`q_total`=2, `p_total`=8), the pump code is 000 and `reserved_err` is 0. `wr_ready` is 0 during reset and becomes 1 at the first edge with `rst_n` high.
- R2: A write is accepted only on an edge where `wr_valid` and `wr_ready` are both high. The written value is visible on `rd_data` for that address from the next cycle. An idle channel changes nothing.
- R3: `q_total` equals bits 6..0 of address 42h plus 2, which gives a range of 2 to 129.
- R4: PB is {40h[1:0], 41h[7:0]} and PO is 42h[7]. `p_total` is 2·(PB+4)+PO.
- R5: `pump_code` is 40h[4:2]. Bits 7..5 of 40h always read 110, whatever value was written.
- R6: Address 12h reads 001dd000, where dd is written bits 4..3. Those two bits drive `drive_sel`. Address 13h stores all 8 bits, which drive `cap_load`.
- R7: Address 09h bits 5..0 drive `out_en`, one bit per output with bit k for output k. Bits 7..6 always read 0.
- R8: Address 46h keeps only written bits 7..6, and bits 5..0 always read 111111. Concatenating 44h, 45h and 46h[7:6] gives an 18-bit chain whose MSB is 44h bit 7. Output k takes its 3-bit source code from chain bits (17-3k)..(15-3k), and that code appears on `xpt_sel[3k+2:3k]`.
- R9: A write to any address other than 09h, 0Ch, 12h, 13h, 40h–42h and 44h–47h changes no register and sets `reserved_err`. The flag stays set until reset. A read from such an address returns 00h.
- R10: `pump_forbidden` is high exactly when the pump code is 101, 110 or 111.
- R11: `p_range_err` is high when `p_total` is outside 16..1023. When `p_total` is inside that range, the required pump code is 000 for 16–44, 001 for 45–479, 010 for 480–639, 011 for 640–799 and 100 for 800–1023. `p_valid` is high when the stored code matches the required code, and `pump_mismatch` is high when it does not.
- R12: 0Ch holds `div1_src` in bit 7 and `div1_n` in bits 6..0, and 47h holds the same fields for divider 2. `div1_low` and `div2_low` are high when the respective divider value is below 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write channel can accept |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Read byte (combinational) |
| reserved_err | output | 1 | Sticky reserved-write flag |
| out_en | output | 6 | Per-output enables |
| div1_src | output | 1 | Divider bank 1 source select |
| div1_n | output | 7 | Divider bank 1 variable divisor |
| div2_src | output | 1 | Divider bank 2 source select |
| div2_n | output | 7 | Divider bank 2 variable divisor |
| div1_low | output | 1 | div1_n below minimum |
| div2_low | output | 1 | div2_n below minimum |
| drive_sel | output | 2 | Oscillator drive setting |
| cap_load | output | 8 | Load-capacitor code |
| xpt_sel | output | 18 | Crosspoint source code per output, 3 bits each |
| q_total | output | 8 | Reference divisor |
| p_total | output | 12 | Feedback multiplier |
| pump_code | output | 3 | Stored charge-pump code |
| p_range_err | output | 1 | Multiplier outside 16..1023 |
| pump_forbidden | output | 1 | Reserved pump code stored |
| pump_mismatch | output | 1 | Pump code wrong for multiplier |
| p_valid | output | 1 | Multiplier in range with matching pump code |

## Verification
The bench builds the bank with its default parameters: a divider minimum of 4 and a multiplier window of 16 to 1023. With those values the multiplier can be placed on both sides of every pump-table edge (15/16, 44/45, 479/480, 639/640, 799/800, 1023/1024), and each of the eight pump codes is tried at each of those points. The read sweep covers all 256 addresses, so every reserved range returns zero. A second reset in the middle of the run shows that the sticky flag and the stored fields are cleared.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  localparam int NUM_SLOTS = 11;
  localparam int NUM_OUTS  = 6;
  localparam int SRC_W     = 3;
  localparam int XPT_W     = NUM_OUTS * SRC_W;

  // storage slot indices
  localparam int S_OE   = 0;
  localparam int S_DIV1 = 1;
  localparam int S_DRV  = 2;
  localparam int S_CAP  = 3;
  localparam int S_PHI  = 4;
  localparam int S_PLO  = 5;
  localparam int S_PQ   = 6;
  localparam int S_XA   = 7;
  localparam int S_XB   = 8;
  localparam int S_XC   = 9;
  localparam int S_DIV2 = 10;

  typedef struct packed {
    logic [NUM_OUTS-1:0] oe;
    logic                div1_src;
    logic [6:0]          div1_n;
    logic [1:0]          drive;
    logic [7:0]          cap;
    logic [2:0]          pump;
    logic [9:0]          pb;
    logic                po;
    logic [6:0]          q;
    logic [XPT_W-1:0]    xpt;
    logic                div2_src;
    logic [6:0]          div2_n;
  } cfg_fields_t;

  function automatic logic [7:0] slot_addr(int i);
    case (i)
      S_OE:    return 8'h09;
      S_DIV1:  return 8'h0C;
      S_DRV:   return 8'h12;
      S_CAP:   return 8'h13;
      S_PHI:   return 8'h40;
      S_PLO:   return 8'h41;
      S_PQ:    return 8'h42;
      S_XA:    return 8'h44;
      S_XB:    return 8'h45;
      S_XC:    return 8'h46;
      S_DIV2:  return 8'h47;
      default: return 8'h00;
    endcase
  endfunction

  // bits taken from the written byte
  function automatic logic [7:0] slot_keep(int i);
    case (i)
      S_OE:    return 8'h3F;
      S_DRV:   return 8'h18;
      S_PHI:   return 8'h1F;
      S_XC:    return 8'hC0;
      default: return 8'hFF;
    endcase
  endfunction

  // bits forced to one; also the reset value of each slot
  function automatic logic [7:0] slot_fix(int i);
    case (i)
      S_DRV:   return 8'h20;
      S_PHI:   return 8'hC0;
      S_XC:    return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] pump_for_ptotal(logic [11:0] p);
    if (p < 12'd45)       return 3'd0;
    else if (p < 12'd480) return 3'd1;
    else if (p < 12'd640) return 3'd2;
    else if (p < 12'd800) return 3'd3;
    else                  return 3'd4;
  endfunction

endpackage

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
  import clkcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [7:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [7:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic        reserved_err,
  output cfg_fields_t fields
);

  logic [NUM_SLOTS-1:0]      wr_hit;
  logic [NUM_SLOTS-1:0]      rd_hit;
  logic [NUM_SLOTS-1:0][7:0] regs_q;
  logic                      ready_q;
  logic                      err_q;
  logic                      fire;
  logic                      wr_live;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      wr_hit[i] = (wr_addr == slot_addr(i));
      rd_hit[i] = (rd_addr == slot_addr(i));
    end
  end

  assign wr_live = |wr_hit;
  assign fire    = wr_valid && ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      for (int i = 0; i < NUM_SLOTS; i++) regs_q[i] <= slot_fix(i);
    end else begin
      ready_q <= 1'b1;
      if (fire && !wr_live) err_q <= 1'b1;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (fire && wr_hit[i]) regs_q[i] <= (wr_data & slot_keep(i)) | slot_fix(i);
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_hit[i]) rd_data = rd_data | regs_q[i];
    end
  end

  assign wr_ready     = ready_q;
  assign reserved_err = err_q;

  always_comb begin
    fields          = '0;
    fields.oe       = regs_q[S_OE][NUM_OUTS-1:0];
    fields.div1_src = regs_q[S_DIV1][7];
    fields.div1_n   = regs_q[S_DIV1][6:0];
    fields.drive    = regs_q[S_DRV][4:3];
    fields.cap      = regs_q[S_CAP];
    fields.pump     = regs_q[S_PHI][4:2];
    fields.pb       = {regs_q[S_PHI][1:0], regs_q[S_PLO]};
    fields.po       = regs_q[S_PQ][7];
    fields.q        = regs_q[S_PQ][6:0];
    fields.xpt      = {regs_q[S_XA], regs_q[S_XB], regs_q[S_XC][7:6]};
    fields.div2_src = regs_q[S_DIV2][7];
    fields.div2_n   = regs_q[S_DIV2][6:0];
  end

  // R9: the error flag never clears outside reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R9: a dropped write leaves every slot as it was
  p_reserved_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_live) |=> $stable(regs_q));

  // R2: with no accepted write, storage holds
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && ready_q) |=> $stable(regs_q));

endmodule

// File: rtl/clkcfg_pll_decode.sv
module clkcfg_pll_decode
  import clkcfg_pkg::*;
#(
  parameter int P_MIN = 16,
  parameter int P_MAX = 1023
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  pb,
  input  logic        po,
  input  logic [6:0]  q,
  input  logic [2:0]  pump,
  output logic [7:0]  q_total,
  output logic [11:0] p_total,
  output logic        p_range_err,
  output logic        pump_forbidden,
  output logic        pump_mismatch,
  output logic        p_valid
);

  localparam logic [11:0] P_LO = 12'(P_MIN);
  localparam logic [11:0] P_HI = 12'(P_MAX);

  logic       in_range;
  logic [2:0] want_pump;

  assign q_total        = {1'b0, q} + 8'd2;
  assign p_total        = {1'b0, pb, 1'b0} + 12'd8 + {11'd0, po};
  assign in_range       = (p_total >= P_LO) && (p_total <= P_HI);
  assign want_pump      = pump_for_ptotal(p_total);
  assign p_range_err    = !in_range;
  assign pump_forbidden = pump[2] && (pump[1:0] != 2'b00);
  assign pump_mismatch  = in_range && (pump != want_pump);
  assign p_valid        = in_range && (pump == want_pump);

  // R11: a valid multiplier always sits inside the window
  p_valid_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid |-> (p_total >= P_LO && p_total <= P_HI));

  // R11: mismatch and valid never coincide
  p_mismatch_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pump_mismatch |-> !p_valid);

  // R10: a reserved pump code is never accepted as valid
  p_forbidden_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pump_forbidden |-> !p_valid);

endmodule

// File: rtl/clkcfg_out_decode.sv
module clkcfg_out_decode
  import clkcfg_pkg::*;
#(
  parameter int DIVN_MIN = 4
) (
  input  cfg_fields_t         fields,
  output logic [NUM_OUTS-1:0] out_en,
  output logic                div1_src,
  output logic [6:0]          div1_n,
  output logic                div2_src,
  output logic [6:0]          div2_n,
  output logic                div1_low,
  output logic                div2_low,
  output logic [1:0]          drive_sel,
  output logic [7:0]          cap_load,
  output logic [XPT_W-1:0]    xpt_sel
);

  localparam logic [6:0] N_MIN = 7'(DIVN_MIN);

  assign out_en    = fields.oe;
  assign div1_src  = fields.div1_src;
  assign div1_n    = fields.div1_n;
  assign div2_src  = fields.div2_src;
  assign div2_n    = fields.div2_n;
  assign div1_low  = fields.div1_n < N_MIN;
  assign div2_low  = fields.div2_n < N_MIN;
  assign drive_sel = fields.drive;
  assign cap_load  = fields.cap;

  // output 0 takes the most significant group of the chain
  for (genvar k = 0; k < NUM_OUTS; k++) begin : g_xpt
    assign xpt_sel[k*SRC_W +: SRC_W] = fields.xpt[XPT_W-1-k*SRC_W -: SRC_W];
  end

endmodule

// File: rtl/clkcfg_bank.sv
module clkcfg_bank
  import clkcfg_pkg::*;
#(
  parameter int DIVN_MIN = 4,
  parameter int P_MIN    = 16,
  parameter int P_MAX    = 1023
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [7:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [7:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic        reserved_err,
  output logic [5:0]  out_en,
  output logic        div1_src,
  output logic [6:0]  div1_n,
  output logic        div2_src,
  output logic [6:0]  div2_n,
  output logic        div1_low,
  output logic        div2_low,
  output logic [1:0]  drive_sel,
  output logic [7:0]  cap_load,
  output logic [17:0] xpt_sel,
  output logic [7:0]  q_total,
  output logic [11:0] p_total,
  output logic [2:0]  pump_code,
  output logic        p_range_err,
  output logic        pump_forbidden,
  output logic        pump_mismatch,
  output logic        p_valid
);

  cfg_fields_t fields;
  logic        fire;

  assign fire = wr_valid && wr_ready;

  clkcfg_regs i_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .reserved_err (reserved_err),
    .fields       (fields)
  );

  clkcfg_pll_decode #(.P_MIN(P_MIN), .P_MAX(P_MAX)) i_pll (
    .clk            (clk),
    .rst_n          (rst_n),
    .pb             (fields.pb),
    .po             (fields.po),
    .q              (fields.q),
    .pump           (fields.pump),
    .q_total        (q_total),
    .p_total        (p_total),
    .p_range_err    (p_range_err),
    .pump_forbidden (pump_forbidden),
    .pump_mismatch  (pump_mismatch),
    .p_valid        (p_valid)
  );

  clkcfg_out_decode #(.DIVN_MIN(DIVN_MIN)) i_out (
    .fields    (fields),
    .out_en    (out_en),
    .div1_src  (div1_src),
    .div1_n    (div1_n),
    .div2_src  (div2_src),
    .div2_n    (div2_n),
    .div1_low  (div1_low),
    .div2_low  (div2_low),
    .drive_sel (drive_sel),
    .cap_load  (cap_load),
    .xpt_sel   (xpt_sel)
  );

  assign pump_code = fields.pump;

  // R1: leaving reset shows the cleared configuration
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_en == 6'd0 && q_total == 8'd2 && p_total == 12'd8
                      && pump_code == 3'd0 && !reserved_err));

  // R3: a write to the Q byte shows up as Q+2 one cycle later
  p_q_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_addr == 8'h42) |=> (q_total == {1'b0, $past(wr_data[6:0])} + 8'd2));

  // R12: a write to divider 1 shows up one cycle later
  p_div1_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_addr == 8'h0C) |=> (div1_n == $past(wr_data[6:0])));

endmodule

// File: tb/test_clkcfg_bank.sv
module test_clkcfg_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_addr = 8'h00;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_addr = 8'h00;
  logic        wr_ready;
  logic [7:0]  rd_data;
  logic        reserved_err;
  logic [5:0]  out_en;
  logic        div1_src, div2_src, div1_low, div2_low;
  logic [6:0]  div1_n, div2_n;
  logic [1:0]  drive_sel;
  logic [7:0]  cap_load;
  logic [17:0] xpt_sel;
  logic [7:0]  q_total;
  logic [11:0] p_total;
  logic [2:0]  pump_code;
  logic        p_range_err, pump_forbidden, pump_mismatch, p_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit started  = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  clkcfg_bank i_clkcfg_bank (.*);

  // ---------------- reference model ----------------
  logic [7:0] m [0:255];
  logic       m_err   = 1'b0;
  logic       m_ready = 1'b0;

  function automatic bit live(logic [7:0] a);
    return a == 8'h09 || a == 8'h0C || a == 8'h12 || a == 8'h13 ||
           (a >= 8'h40 && a <= 8'h42) || (a >= 8'h44 && a <= 8'h47);
  endfunction

  function automatic logic [7:0] shaped(logic [7:0] a, logic [7:0] d);
    case (a)
      8'h09:   return {2'b00, d[5:0]};
      8'h12:   return {3'b001, d[4:3], 3'b000};
      8'h40:   return {3'b110, d[4:0]};
      8'h46:   return {d[7:6], 6'b111111};
      default: return d;
    endcase
  endfunction

  function automatic int need_pump(int p);
    if (p <= 44)  return 0;
    if (p <= 479) return 1;
    if (p <= 639) return 2;
    if (p <= 799) return 3;
    return 4;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      for (int a = 0; a < 256; a++) m[a] = 8'h00;
      m[8'h12] = 8'h20; m[8'h40] = 8'hC0; m[8'h46] = 8'h3F;
      m_err = 0; m_ready = 0;
    end else begin
      if (wr_valid && m_ready) begin
        if (live(wr_addr)) m[wr_addr] = shaped(wr_addr, wr_data);
        else               m_err = 1;
      end
      m_ready = 1;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, well after the edge and the negedge drive
  always begin
    @(posedge clk);
    #6;
    if (started) begin
      int pb, po, q, pt, pu, chain;
      bit inr;
      pb = ((int'(m[8'h40]) & 3) << 8) | int'(m[8'h41]);
      po = int'(m[8'h42]) >> 7;
      q  = int'(m[8'h42]) & 127;
      pt = 2 * (pb + 4) + po;
      pu = (int'(m[8'h40]) >> 2) & 7;
      inr = (pt >= 16) && (pt <= 1023);
      chain = (int'(m[8'h44]) << 10) | (int'(m[8'h45]) << 2) | (int'(m[8'h46]) >> 6);
      chk("R1", "wr_ready", 32'(wr_ready), 32'(m_ready));
      chk("R2", "rd_data", 32'(rd_data), live(rd_addr) ? 32'(m[rd_addr]) : 32'h0);
      chk("R9", "reserved_err", 32'(reserved_err), 32'(m_err));
      chk("R3", "q_total", 32'(q_total), 32'(q + 2));
      chk("R4", "p_total", 32'(p_total), 32'(pt));
      chk("R5", "pump_code", 32'(pump_code), 32'(pu));
      chk("R6", "drive_sel", 32'(drive_sel), 32'((int'(m[8'h12]) >> 3) & 3));
      chk("R6", "cap_load", 32'(cap_load), 32'(m[8'h13]));
      chk("R7", "out_en", 32'(out_en), 32'(int'(m[8'h09]) & 63));
      for (int k = 0; k < 6; k++)
        chk("R8", "xpt_sel", 32'((xpt_sel >> (3 * k)) & 18'd7), 32'((chain >> (15 - 3 * k)) & 7));
      chk("R10", "pump_forbidden", 32'(pump_forbidden), 32'(pu >= 5));
      chk("R11", "p_range_err", 32'(p_range_err), 32'(!inr));
      chk("R11", "p_valid", 32'(p_valid), 32'(inr && pu == need_pump(pt)));
      chk("R11", "pump_mismatch", 32'(pump_mismatch), 32'(inr && pu != need_pump(pt)));
      chk("R12", "div1_src", 32'(div1_src), 32'(int'(m[8'h0C]) >> 7));
      chk("R12", "div1_n", 32'(div1_n), 32'(int'(m[8'h0C]) & 127));
      chk("R12", "div1_low", 32'(div1_low), 32'((int'(m[8'h0C]) & 127) < 4));
      chk("R12", "div2_src", 32'(div2_src), 32'(int'(m[8'h47]) >> 7));
      chk("R12", "div2_n", 32'(div2_n), 32'(int'(m[8'h47]) & 127));
      chk("R12", "div2_low", 32'(div2_low), 32'((int'(m[8'h47]) & 127) < 4));
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d; rd_addr = a;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic set_p(int pb, int po, int pump);
    put(8'h41, 8'(pb & 255));
    put(8'h42, 8'((po << 7) | 5));
    put(8'h40, 8'((pump << 2) | (pb >> 8)));
  endtask

  initial begin
    int pbs[] = '{0, 3, 4, 18, 235, 236, 315, 316, 395, 396, 507, 508, 1023};
    logic [7:0] live_addrs[] = '{8'h09, 8'h0C, 8'h12, 8'h13, 8'h40, 8'h41, 8'h42,
                                 8'h44, 8'h45, 8'h46, 8'h47};
    logic [7:0] rsv[] = '{8'h00, 8'h08, 8'h0A, 8'h0B, 8'h0D, 8'h11, 8'h14, 8'h3F,
                          8'h43, 8'h48, 8'hFF};
    repeat (3) @(negedge clk);
    // R1: offer a write while reset is still pending release
    rst_n = 1;
    wr_valid = 1; wr_addr = 8'h09; wr_data = 8'h3F;
    @(negedge clk);
    wr_valid = 0;
    repeat (2) @(negedge clk);
    // R5 R6 R7 R8: forced bits under several patterns
    foreach (live_addrs[i]) begin
      put(live_addrs[i], 8'hFF);
      put(live_addrs[i], 8'hA5);
      put(live_addrs[i], 8'h5A);
    end
    // R2: idle gaps with junk on the bus
    @(negedge clk); wr_addr = 8'h13; wr_data = 8'h77;
    repeat (3) @(negedge clk);
    // R9: reserved writes
    foreach (rsv[i]) put(rsv[i], 8'hFF);
    // R10 R11: every pump code at each table edge, PO both ways
    foreach (pbs[i]) for (int po = 0; po < 2; po++) for (int pu = 0; pu < 8; pu++)
      set_p(pbs[i], po, pu);
    // R3: Q extremes
    put(8'h42, 8'h7F);
    put(8'h42, 8'h00);
    // R12: divider edges
    for (int n = 0; n < 6; n++) begin
      put(8'h0C, 8'(n | 8'h80));
      put(8'h47, 8'(n));
    end
    put(8'h0C, 8'h7F);
    put(8'h47, 8'hFF);
    // R8: distinct crosspoint codes
    put(8'h44, 8'b000_001_01);
    put(8'h45, 8'b0_011_100_1);
    put(8'h46, 8'b01_000000);
    // R9: read sweep of every address
    for (int a = 0; a < 256; a++) begin
      @(negedge clk); rd_addr = 8'(a);
    end
    // R1: mid-run reset clears flag and fields
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "out_en after reset", 32'(out_en), 32'h0);
    chk("R1", "reserved_err after reset", 32'(reserved_err), 32'h0);
    put(8'h09, 8'h15);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule